// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Clock Polarity Select

This block is a master-side, clocked synchronous serial port. It exchanges 8-bit frames full duplex: a transmit line and a receive line carry one bit each per serial clock period, and the serial clock is generated inside the block by a programmable divider from the system clock. A host writes a byte and pulses a start strobe. It watches a busy flag and picks up the received byte when a one-cycle done pulse appears.

A single polarity setting fixes three things at once: the edge on which transmit data is launched, the edge on which receive data is captured, and the level at which the serial clock rests between frames. Two further settings select the bit order (low bit or high bit first) and invert the data on both lines. All settings, together with the divider value, are held in configuration registers. These registers accept a write only while no frame is running.

Top module: `sync_serial_xcvr`

## Requirements
- R1: While no frame is running, `sclk` rests at the inverse of the polarity setting: high when `cfg_pol`=0, low when `cfg_pol`=1. An accepted configuration write moves the idle level in the same cycle that the register updates.
- R2: With polarity 0, `sdo` changes only on falling `sclk` edges and `sdi` is captured on rising `sclk` edges.
- R3: With polarity 1, `sdo` changes only on rising `sclk` edges and `sdi` is captured on falling `sclk` edges.
- R4: A frame carries 8 bits in each direction at the same time. Each `sclk` half period lasts `cfg_div`+1 system cycles, so `busy` stays high for exactly 16*(`cfg_div`+1) cycles.
- R5: With `cfg_msb_first`=0, bit 0 of the byte is the first bit on `sdo`. The first bit captured from `sdi` is stored in bit 0 of `rx_data`.
- R6: With `cfg_msb_first`=1, bit 7 is the first bit on `sdo`. The first bit captured from `sdi` is stored in bit 7 of `rx_data`.
- R7: With `cfg_invert`=1, every transmitted bit is driven inverted and every captured bit is inverted before it is stored. With `cfg_invert`=0, bits travel at their true levels.
- R8: On the cycle after an accepted start, `busy` is high, `sclk` has left its idle level, and the first data bit is already on `sdo`. This is one half period before the first capture edge.
- R9: When the frame ends, `busy` falls and `done` is high for exactly one cycle. In that same cycle `rx_data` holds the received byte.
- R10: A configuration write or a start strobe issued while `busy` is high is ignored. The running frame completes with its original settings and data.
- R11: After reset, `busy`=0, `done`=0, `sclk`=1, `sdo`=1 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe (accepted only when idle) |
| cfg_pol | input | 1 | Clock polarity setting |
| cfg_msb_first | input | 1 | Bit order: 1 sends/stores bit 7 first |
| cfg_invert | input | 1 | Data inversion on both lines |
| cfg_div | input | 8 | Half period minus one, in system cycles |
| tx_data | input | 8 | Byte to transmit, taken on an accepted start |
| start | input | 1 | Frame start strobe (ignored while busy) |
| rx_data | output | 8 | Last received byte |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial transmit data (high when idle) |
| sdi | input | 1 | Serial receive data |

## Verification
The bound checker watches the cycle-level rules on every cycle: the idle level of `sclk` against the stored polarity, the direction in which `sclk` leaves idle at a frame start, the single-cycle `done` pulse tied to the fall of `busy`, and the configuration holding still for the whole frame. Only the bench's frames can show the serial content. A bench slave drives `sdi` on launch edges and records `sdo` on capture edges, which confirms the edge pairing per polarity, the bit order and inversion in both directions, the frame length for each divider value, and that strobes issued mid-frame leave the running transfer untouched.

// File: rtl/ssx_pkg.sv
// Package ssx_pkg
// Shared types for the synchronous serial transceiver.
// Assumes: the frame settings are a small packed group that is registered as one unit.
package ssx_pkg;

    // Frame settings that stay fixed for the whole of a frame
    typedef struct packed {
        logic pol;        // 0: launch falling / capture rising / idle high
        logic msb_first;  // 1: high bit travels first
        logic invert;     // 1: line levels are complemented
    } ssx_cfg_t;

endpackage

// File: rtl/ssx_timing.sv
// Module ssx_timing
// Generates the serial clock and the frame sequencing. A frame has 2*BITS half
// periods, and each half period lasts div+1 system cycles. Even halves hold the
// clock at the launch level (pol). Odd halves hold it at the capture level (~pol).
// The block emits one-cycle ticks for capture, launch and end of frame.
// Assumes: pol and div do not change while busy (the top guarantees this).
module ssx_timing #(
    parameter int BITS  = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_ok,
    input  logic             pol,
    input  logic [DIV_W-1:0] div,
    output logic             busy,
    output logic             sclk,
    output logic             smp_tick,
    output logic             lch_tick,
    output logic             end_tick
);
    localparam int HALVES = 2 * BITS;
    localparam int HALF_W = $clog2(HALVES);

    logic [DIV_W-1:0]  div_cnt;
    logic [HALF_W-1:0] half_cnt;
    logic              tick;
    logic              last_half;

    // Decode the half-period boundary and classify the edge it produces
    always_comb begin
        tick      = busy && (div_cnt == div);
        last_half = (half_cnt == HALF_W'(HALVES - 1));
        smp_tick  = tick && !half_cnt[0];
        lch_tick  = tick && half_cnt[0] && !last_half;
        end_tick  = tick && last_half;
    end

    // Advance the divider, the half-period count and the serial clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            half_cnt <= '0;
            div_cnt  <= '0;
            sclk     <= 1'b1;
        end else if (start_ok) begin
            busy     <= 1'b1;
            half_cnt <= '0;
            div_cnt  <= '0;
            sclk     <= pol;
        end else if (busy) begin
            if (tick) begin
                div_cnt <= '0;
                if (last_half) begin
                    busy <= 1'b0;
                    sclk <= ~pol;
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                    sclk     <= ~sclk;
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end else begin
            sclk <= ~pol;
        end
    end

endmodule

// File: rtl/ssx_datapath.sv
// Module ssx_datapath
// Holds the transmit and receive shift registers. It loads the outgoing byte on a
// start, moves to the next outgoing bit on each launch tick, captures the
// incoming line on each capture tick, and publishes the received byte with a
// one-cycle done pulse at the end of the frame.
// Assumes: cfg is stable from load until end_tick.
module ssx_datapath
    import ssx_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] tx_data,
    input  ssx_cfg_t        cfg,
    input  logic            smp_tick,
    input  logic            lch_tick,
    input  logic            end_tick,
    input  logic            sdi,
    output logic            sdo,
    output logic [BITS-1:0] rx_data,
    output logic            done
);
    logic [BITS-1:0] tx_sh;
    logic [BITS-1:0] rx_sh;
    logic [BITS-1:0] load_val;
    logic [BITS-1:0] tx_next;
    logic [BITS-1:0] rx_next;
    logic            load_bit;
    logic            next_bit;
    logic            rx_bit;

    // Prepare the loaded word, the shifted word and the bit each exposes on the line
    always_comb begin
        load_val = tx_data ^ {BITS{cfg.invert}};
        load_bit = cfg.msb_first ? load_val[BITS-1] : load_val[0];
        tx_next  = cfg.msb_first ? (tx_sh << 1) : (tx_sh >> 1);
        next_bit = cfg.msb_first ? tx_next[BITS-1] : tx_next[0];
        rx_bit   = sdi ^ cfg.invert;
        rx_next  = cfg.msb_first ? {rx_sh[BITS-2:0], rx_bit}
                                 : {rx_bit, rx_sh[BITS-1:1]};
    end

    // Transmit shifter and line driver; the line rests high between frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
            sdo   <= 1'b1;
        end else if (load) begin
            tx_sh <= load_val;
            sdo   <= load_bit;
        end else if (lch_tick) begin
            tx_sh <= tx_next;
            sdo   <= next_bit;
        end else if (end_tick) begin
            sdo   <= 1'b1;
        end
    end

    // Receive shifter, published byte and end-of-frame pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rx_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= end_tick;
            if (smp_tick) begin
                rx_sh <= rx_next;
            end
            if (end_tick) begin
                rx_data <= rx_sh;
            end
        end
    end

endmodule

// File: rtl/sync_serial_xcvr.sv
// Module sync_serial_xcvr
// Top of the master-mode synchronous serial transceiver. It registers the frame
// settings and the divider value, which accept writes only while idle. It
// qualifies the start strobe and connects the timing and data path submodules.
// Assumes: sdi is driven by a partner that changes it on launch edges of sclk.
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_pol,
    input  logic              cfg_msb_first,
    input  logic              cfg_invert,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              start,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi
);
    ssx_cfg_t         cfg_q;
    ssx_cfg_t         cfg_d;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_d;
    logic             cfg_ok;
    logic             start_ok;
    logic             smp_tick;
    logic             lch_tick;
    logic             end_tick;

    // Accept strobes only while idle; a same-cycle write applies to the new frame
    always_comb begin
        cfg_ok   = cfg_we && !busy;
        start_ok = start && !busy;
        cfg_d    = cfg_ok ? '{pol: cfg_pol, msb_first: cfg_msb_first, invert: cfg_invert}
                          : cfg_q;
        div_d    = cfg_ok ? cfg_div : div_q;
    end

    // Settings registers, frozen while a frame runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            div_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            div_q <= div_d;
        end
    end

    ssx_timing #(
        .BITS  (DATA_W),
        .DIV_W (DIV_W)
    ) u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .pol      (cfg_d.pol),
        .div      (div_d),
        .busy     (busy),
        .sclk     (sclk),
        .smp_tick (smp_tick),
        .lch_tick (lch_tick),
        .end_tick (end_tick)
    );

    ssx_datapath #(
        .BITS (DATA_W)
    ) u_datapath (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .tx_data  (tx_data),
        .cfg      (cfg_d),
        .smp_tick (smp_tick),
        .lch_tick (lch_tick),
        .end_tick (end_tick),
        .sdi      (sdi),
        .sdo      (sdo),
        .rx_data  (rx_data),
        .done     (done)
    );

endmodule

// File: rtl/ssx_checker.sv
// Module ssx_checker
// Cycle-level properties of sync_serial_xcvr, attached to it by bind.
// Assumes: it sees the top's ports and its registered settings.
module ssx_checker
    import ssx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             sclk,
    input ssx_cfg_t         cfg_q,
    input logic [DIV_W-1:0] div_q
);
    // R1: the idle clock level is the inverse of the stored polarity
    a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == ~cfg_q.pol));

    // R8: at a frame start the clock leaves idle towards the launch level
    a_r8_start_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sclk == cfg_q.pol));

    // R9: the end of a frame produces done
    a_r9_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done is only seen while idle
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: settings stay frozen while a frame runs
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(cfg_q) && $stable(div_q)));

endmodule

bind sync_serial_xcvr ssx_checker #(.DIV_W(DIV_W)) u_ssx_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .cfg_q (cfg_q),
    .div_q (div_q)
);

// File: tb/test_sync_serial_xcvr.sv
// Bench for sync_serial_xcvr: directed corner frames plus seeded random frames.
// A behavioural slave drives sdi on launch edges and records sdo on capture edges.
module test_sync_serial_xcvr;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_pol = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_invert = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic [7:0] tx_data = 8'd0;
    logic       start = 1'b0;
    logic [7:0] rx_data;
    logic       busy;
    logic       done;
    logic       sclk;
    logic       sdo;
    logic       sdi = 1'b0;

    int n_checks = 0;
    int n_errors = 0;

    // slave model state
    logic       in_frame = 1'b0;
    logic       mon_pol = 1'b0;
    logic       mon_msb = 1'b0;
    logic [7:0] slv_byte = 8'd0;
    logic [7:0] cap = 8'd0;
    int         lidx = 0;
    int         sidx = 0;

    sync_serial_xcvr i_sync_serial_xcvr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_pol       (cfg_pol),
        .cfg_msb_first (cfg_msb_first),
        .cfg_invert    (cfg_invert),
        .cfg_div       (cfg_div),
        .tx_data       (tx_data),
        .start         (start),
        .rx_data       (rx_data),
        .busy          (busy),
        .done          (done),
        .sclk          (sclk),
        .sdo           (sdo),
        .sdi           (sdi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slave: a move to the launch level drives the next bit, a move to the capture level records sdo
    always @(sclk) begin
        if (in_frame) begin
            if (sclk == mon_pol) begin
                if (lidx < 8) sdi = mon_msb ? slv_byte[7-lidx] : slv_byte[lidx];
                lidx++;
            end else begin
                if (sidx < 8) cap[sidx] = sdo;
                sidx++;
            end
        end
    end

    function automatic logic exp_line_bit(logic [7:0] b, int i, logic msb, logic inv);
        return (msb ? b[7-i] : b[i]) ^ inv;
    endfunction

    function automatic logic [7:0] exp_rx(logic [7:0] s, logic inv);
        return s ^ {8{inv}};
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // Run one frame; with poke set, strobes are issued mid-frame and must be ignored (R10)
    task automatic run_frame(input logic [7:0] tx, input logic [7:0] slv, input logic pol,
                             input logic msb, input logic inv, input logic [7:0] dv,
                             input logic poke);
        int cnt;
        logic [7:0] exp_cap;
        @(negedge clk);
        cfg_we = 1'b1; cfg_pol = pol; cfg_msb_first = msb; cfg_invert = inv; cfg_div = dv;
        @(negedge clk);
        cfg_we = 1'b0;
        check(sclk == ~pol, "R1 idle level", sclk, ~pol);
        mon_pol = pol; mon_msb = msb; slv_byte = slv; lidx = 0; sidx = 0; cap = 8'd0;
        in_frame = 1'b1;
        tx_data = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R8 busy after start", busy, 1);
        check(sclk == pol, "R8 clock left idle", sclk, pol);
        check(sdo == exp_line_bit(tx, 0, msb, inv), "R8 first bit ready", sdo,
              exp_line_bit(tx, 0, msb, inv));
        cnt = 1;
        while (busy && cnt < 5000) begin
            if (poke && cnt == 3) begin
                cfg_we = 1'b1; cfg_pol = ~pol; cfg_msb_first = ~msb; cfg_invert = ~inv;
                cfg_div = dv + 8'd1; start = 1'b1; tx_data = ~tx;
            end else begin
                cfg_we = 1'b0; start = 1'b0;
            end
            @(negedge clk);
            if (busy) cnt++;
        end
        cfg_we = 1'b0; start = 1'b0;
        check(cnt == 16 * (int'(dv) + 1), "R4 frame length", cnt, 16 * (int'(dv) + 1));
        check(done == 1'b1, "R9 done at end", done, 1);
        check(rx_data == exp_rx(slv, inv), msb ? "R6 R7 rx byte" : "R5 R7 rx byte",
              rx_data, exp_rx(slv, inv));
        for (int i = 0; i < 8; i++) exp_cap[i] = exp_line_bit(tx, i, msb, inv);
        check(cap == exp_cap, pol ? "R3 R5 R6 R7 tx bits" : "R2 R5 R6 R7 tx bits",
              cap, exp_cap);
        check(lidx == 8 && sidx == 8, pol ? "R3 edge counts" : "R2 edge counts",
              lidx * 16 + sidx, 8 * 16 + 8);
        if (poke) check(sclk == ~pol, "R10 ignored cfg write", sclk, ~pol);
        @(negedge clk);
        in_frame = 1'b0;
        check(done == 1'b0, "R9 done one cycle", done, 0);
        check(busy == 1'b0, "R10 ignored start", busy, 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R11 busy", busy, 0);
        check(done == 1'b0, "R11 done", done, 0);
        check(sclk == 1'b1, "R11 sclk", sclk, 1);
        check(sdo == 1'b1, "R11 sdo", sdo, 1);
        check(rx_data == 8'h00, "R11 rx_data", rx_data, 0);

        // directed corners
        run_frame(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0);
        run_frame(8'h81, 8'hF0, 1'b1, 1'b1, 1'b0, 8'd3, 1'b0);
        run_frame(8'h0F, 8'h96, 1'b0, 1'b1, 1'b1, 8'd1, 1'b0);
        run_frame(8'hC3, 8'h01, 1'b1, 1'b0, 1'b1, 8'd2, 1'b0);
        run_frame(8'h5A, 8'h7E, 1'b0, 1'b0, 1'b0, 8'd2, 1'b1);
        run_frame(8'h12, 8'hED, 1'b1, 1'b1, 1'b1, 8'd4, 1'b1);
        run_frame(8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'd255, 1'b0);

        // R1: idle level follows a write made between frames
        @(negedge clk);
        cfg_we = 1'b1; cfg_pol = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        check(sclk == 1'b0, "R1 idle low for polarity 1", sclk, 0);
        cfg_we = 1'b1; cfg_pol = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        check(sclk == 1'b1, "R1 idle high for polarity 0", sclk, 1);

        // seeded random frames
        for (int k = 0; k < 24; k++) begin
            run_frame(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 8'($urandom % 4), 1'($urandom % 4 == 0));
        end

        summary();
        $finish;
    end

endmodule